// File: doc/BRIEF.md
# GPIO Pin-Mux Select Register Bank

This block holds two 32-bit control words for a group of twelve pins. The first word, the mode word, picks for each pin whether the pad carries the pin's native function or acts as a general-purpose I/O. The second word, the direction word, picks for a GPIO-mode pin whether it drives the pad or only senses it. Bit 0 of each word belongs to the lowest pin of the group. Software reaches the words through a plain register port: a write strobe, a byte address, a 4-bit byte enable, write data and combinational read data.

Behind the registers, a mux for each pin routes the pad. In native mode the native logic's output and output enable reach the pad, and the native logic sees the pad input. In GPIO mode the GPIO output value drives the pad when the pin's direction is output. The native logic is then given a fixed inactive level, set per pin by a parameter, instead of the pad value. The raw pad input always reaches the GPIO side.

Bits are split between two power domains by byte lane. A resume reset restores every bit. A platform reset restores only the core-domain bits. A static strap selects the desktop or mobile variant, which changes which bits exist and what the mode word resets to.

Top module: `gpio_mux_bank`

## Requirements
- R1: The mode word is read at byte address 0x40. Only bits 11:0 hold state, and bits 31:12 always read 0 whatever is written to them.
- R2: The direction word is read at byte address 0x44, where 1 means input and 0 means output. Only bits 11:8 and 3:0 hold state, and bits 7:4 and 31:12 always read 0.
- R3: In the desktop variant (strap low), mode bit 8 always reads 1 and bit 9 of both words always reads 0. Writes to these bits have no effect. In the mobile variant (strap high), bits 8 and 9 are ordinary read/write bits.
- R4: After a resume reset, the desktop variant reads mode 0x130 and direction 0xD00. The mobile variant reads mode 0x030 and direction 0xF00.
- R5: A write changes only the bytes whose enable bit is set, with enable bit k covering data bits 8k+7:8k. Any address other than 0x40 and 0x44 reads 0, and a write to such an address changes neither word.
- R6: A platform reset restores bits 7:0 of both words to their reset values and leaves bits 11:8 unchanged. A write to bits 11:8 that falls during a platform reset still takes effect.
- R7: A resume reset restores bits 11:0 of both words regardless of the platform reset.
- R8: A pin whose mode bit reads 1 drives pad_out from gpio_out, and its pad_oe is the inverse of its direction bit as read back. A pin whose mode bit reads 0 drives pad_out and pad_oe from native_out and native_oe.
- R9: native_in equals the pin's NATIVE_IDLE parameter bit when the mode bit reads 1, and equals pad_in when it reads 0.
- R10: gpio_in equals pad_in for every pin, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_resume_n | input | 1 | Resume-domain reset, asynchronous, active low, restores all bits |
| rst_platform_n | input | 1 | Platform reset, asynchronous, active low, restores core-domain bits |
| variant_mobile | input | 1 | Static variant strap: 1 mobile, 0 desktop |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 8 | Byte address of the word |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| native_out | input | 12 | Native function output per pin |
| native_oe | input | 12 | Native function output enable per pin |
| native_in | output | 12 | Pad input as seen by native logic |
| gpio_out | input | 12 | GPIO output value per pin |
| gpio_in | output | 12 | Pad input as seen by the GPIO side |
| pad_in | input | 12 | Value sensed at each pad |
| pad_out | output | 12 | Value driven to each pad |
| pad_oe | output | 12 | Output enable to each pad |

## Verification
A register write and a platform reset can land on the same clock edge. When that happens, the resume-domain byte must take the write while the core-domain byte stays at its reset value. The bench provokes this by holding the platform reset low while it writes all ones to both mode bytes. After releasing the reset, it reads back and expects the resume byte written and the core byte at its reset value. The same sequence is preceded by a platform reset on written data, so that the retained upper bits and the restored lower bits are each judged against values worked out from the requirements.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  localparam int unsigned LANE_BITS = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MODE = 2'd1,
    SEL_DIR  = 2'd2
  } word_sel_e;

  // Even byte lanes sit in the core domain, odd lanes in the resume domain.
  function automatic bit lane_is_core(input int unsigned bit_idx);
    return ((bit_idx / LANE_BITS) % 2) == 0;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_sel_reg.sv
module gpio_sel_reg
  import gpio_mux_pkg::*;
#(
  parameter int unsigned         WIDTH  = 12,
  parameter logic [WIDTH-1:0]    IMPL   = '1,
  localparam int unsigned        NBYTES = (WIDTH + LANE_BITS - 1) / LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              rst_resume_n,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [WIDTH-1:0]  wr_mask,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  rst_val,
  output logic [WIDTH-1:0]  q
);

  logic unused_inputs;
  assign unused_inputs = ^((wr_data | wr_mask | rst_val) & ~IMPL);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic bit_d;
      logic bit_q;

      always_comb begin
        if (wr_en && wr_be[i / LANE_BITS] && wr_mask[i]) begin
          bit_d = wr_data[i];
        end else begin
          bit_d = bit_q;
        end
      end

      if (lane_is_core(i)) begin : g_core
        always_ff @(posedge clk or negedge rst_core_n) begin
          if (!rst_core_n) begin
            bit_q <= rst_val[i];
          end else begin
            bit_q <= bit_d;
          end
        end
      end else begin : g_resume
        always_ff @(posedge clk or negedge rst_resume_n) begin
          if (!rst_resume_n) begin
            bit_q <= rst_val[i];
          end else begin
            bit_q <= bit_d;
          end
        end
      end

      assign q[i] = bit_q;
    end else begin : g_absent
      assign q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic gpio_mode,
  input  logic gpio_dir_in,
  input  logic native_out,
  input  logic native_oe,
  input  logic gpio_out,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic native_in,
  output logic gpio_in
);

  always_comb begin
    if (gpio_mode) begin
      pad_out   = gpio_out;
      pad_oe    = ~gpio_dir_in;
      native_in = IDLE_LEVEL;
    end else begin
      pad_out   = native_out;
      pad_oe    = native_oe;
      native_in = pad_in;
    end
    gpio_in = pad_in;
  end

endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_mux_pkg::*;
#(
  parameter int unsigned           NPINS        = 12,
  parameter int unsigned           DATA_W       = 32,
  parameter int unsigned           ADDR_W       = 8,
  parameter logic [ADDR_W-1:0]     MODE_OFS     = 8'h40,
  parameter logic [ADDR_W-1:0]     DIR_OFS      = 8'h44,
  parameter logic [NPINS-1:0]      MODE_IMPL    = 12'hFFF,
  parameter logic [NPINS-1:0]      DIR_IMPL     = 12'hF0F,
  parameter logic [NPINS-1:0]      DESK_FORCE1  = 12'h100,
  parameter logic [NPINS-1:0]      MOBILE_ONLY  = 12'h200,
  parameter logic [NPINS-1:0]      MODE_RST_DSK = 12'h130,
  parameter logic [NPINS-1:0]      MODE_RST_MOB = 12'h030,
  parameter logic [NPINS-1:0]      DIR_RST      = 12'hF00,
  parameter logic [NPINS-1:0]      NATIVE_IDLE  = 12'hA5C,
  localparam int unsigned          NBYTES       = (NPINS + LANE_BITS - 1) / LANE_BITS,
  localparam int unsigned          BE_W         = DATA_W / LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_resume_n,
  input  logic              rst_platform_n,
  input  logic              variant_mobile,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BE_W-1:0]   reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NPINS-1:0]  native_out,
  input  logic [NPINS-1:0]  native_oe,
  output logic [NPINS-1:0]  native_in,
  input  logic [NPINS-1:0]  gpio_out,
  output logic [NPINS-1:0]  gpio_in,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);

  // Reset distribution: resume reset covers the core domain as well.
  logic core_arst_n;
  logic core_rst_n;
  logic resume_rst_n;

  assign core_arst_n = rst_resume_n & rst_platform_n;

  gpio_rst_sync #(.STAGES(2)) i_sync_core (
    .clk    (clk),
    .arst_n (core_arst_n),
    .srst_n (core_rst_n)
  );

  gpio_rst_sync #(.STAGES(2)) i_sync_resume (
    .clk    (clk),
    .arst_n (rst_resume_n),
    .srst_n (resume_rst_n)
  );

  // Variant-dependent masks.
  logic [NPINS-1:0] exist_mask;
  logic [NPINS-1:0] force1_mask;
  logic [NPINS-1:0] mode_wmask;
  logic [NPINS-1:0] dir_wmask;
  logic [NPINS-1:0] mode_rst_val;

  always_comb begin
    exist_mask   = variant_mobile ? {NPINS{1'b1}} : ~MOBILE_ONLY;
    force1_mask  = variant_mobile ? '0 : DESK_FORCE1;
    mode_wmask   = MODE_IMPL & exist_mask & ~force1_mask;
    dir_wmask    = DIR_IMPL & exist_mask;
    mode_rst_val = variant_mobile ? MODE_RST_MOB : MODE_RST_DSK;
  end

  // Address decode.
  word_sel_e sel;

  always_comb begin
    if (reg_addr == MODE_OFS) begin
      sel = SEL_MODE;
    end else if (reg_addr == DIR_OFS) begin
      sel = SEL_DIR;
    end else begin
      sel = SEL_NONE;
    end
  end

  logic mode_we;
  logic dir_we;

  assign mode_we = reg_wr && (sel == SEL_MODE);
  assign dir_we  = reg_wr && (sel == SEL_DIR);

  logic [NPINS-1:0] mode_q;
  logic [NPINS-1:0] dir_q;

  gpio_sel_reg #(.WIDTH(NPINS), .IMPL(MODE_IMPL)) i_mode_reg (
    .clk          (clk),
    .rst_core_n   (core_rst_n),
    .rst_resume_n (resume_rst_n),
    .wr_en        (mode_we),
    .wr_be        (reg_be[NBYTES-1:0]),
    .wr_mask      (mode_wmask),
    .wr_data      (reg_wdata[NPINS-1:0]),
    .rst_val      (mode_rst_val),
    .q            (mode_q)
  );

  gpio_sel_reg #(.WIDTH(NPINS), .IMPL(DIR_IMPL)) i_dir_reg (
    .clk          (clk),
    .rst_core_n   (core_rst_n),
    .rst_resume_n (resume_rst_n),
    .wr_en        (dir_we),
    .wr_be        (reg_be[NBYTES-1:0]),
    .wr_mask      (dir_wmask),
    .wr_data      (reg_wdata[NPINS-1:0]),
    .rst_val      (DIR_RST),
    .q            (dir_q)
  );

  logic unused_bus;
  assign unused_bus = ^{reg_wdata[DATA_W-1:NPINS], reg_be[BE_W-1:NBYTES]};

  // Visible values.
  logic [NPINS-1:0] mode_rd;
  logic [NPINS-1:0] dir_rd;

  always_comb begin
    mode_rd = (mode_q & mode_wmask) | force1_mask;
    dir_rd  = dir_q & dir_wmask;
  end

  always_comb begin
    unique case (sel)
      SEL_MODE: reg_rdata = {{(DATA_W-NPINS){1'b0}}, mode_rd};
      SEL_DIR:  reg_rdata = {{(DATA_W-NPINS){1'b0}}, dir_rd};
      default:  reg_rdata = '0;
    endcase
  end

  // Per-pin routing.
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_mux #(.IDLE_LEVEL(NATIVE_IDLE[p])) i_mux (
      .gpio_mode   (mode_rd[p]),
      .gpio_dir_in (dir_rd[p]),
      .native_out  (native_out[p]),
      .native_oe   (native_oe[p]),
      .gpio_out    (gpio_out[p]),
      .pad_in      (pad_in[p]),
      .pad_out     (pad_out[p]),
      .pad_oe      (pad_oe[p]),
      .native_in   (native_in[p]),
      .gpio_in     (gpio_in[p])
    );
  end

endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk #(
  parameter int unsigned       NPINS       = 12,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] MODE_OFS    = 8'h40,
  parameter logic [ADDR_W-1:0] DIR_OFS     = 8'h44,
  parameter logic [NPINS-1:0]  DIR_IMPL    = 12'hF0F,
  parameter logic [NPINS-1:0]  DESK_FORCE1 = 12'h100,
  parameter logic [NPINS-1:0]  NATIVE_IDLE = 12'hA5C
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              variant_mobile,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  mode_rd,
  input logic [NPINS-1:0]  dir_rd,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  native_in,
  input logic [NPINS-1:0]  pad_oe
);

  assert_mode_upper_zero_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_addr == MODE_OFS) |-> (reg_rdata[DATA_W-1:NPINS] == '0));

  assert_dir_gap_zero_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_addr == DIR_OFS) |-> ((reg_rdata[DATA_W-1:NPINS] == '0) &&
                               ((reg_rdata[NPINS-1:0] & ~DIR_IMPL) == '0)));

  assert_desk_fixed_one_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!variant_mobile && reg_addr == MODE_OFS) |->
      ((reg_rdata[NPINS-1:0] & DESK_FORCE1) == DESK_FORCE1));

  assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!reg_wr || (reg_addr != MODE_OFS && reg_addr != DIR_OFS)) |=>
      ($stable(mode_q) && $stable(dir_q)));

  assert_native_idle_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((native_in & mode_rd) == (NATIVE_IDLE & mode_rd)) &&
    ((native_in & ~mode_rd) == (pad_in & ~mode_rd)));

  assert_input_pin_quiet_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (pad_oe & mode_rd & dir_rd) == '0);

endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(
  .NPINS       (NPINS),
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .MODE_OFS    (MODE_OFS),
  .DIR_OFS     (DIR_OFS),
  .DIR_IMPL    (DIR_IMPL),
  .DESK_FORCE1 (DESK_FORCE1),
  .NATIVE_IDLE (NATIVE_IDLE)
) i_gpio_mux_bank_chk (
  .clk            (clk),
  .core_rst_n     (core_rst_n),
  .variant_mobile (variant_mobile),
  .reg_wr         (reg_wr),
  .reg_addr       (reg_addr),
  .reg_rdata      (reg_rdata),
  .mode_q         (mode_q),
  .dir_q          (dir_q),
  .mode_rd        (mode_rd),
  .dir_rd         (dir_rd),
  .pad_in         (pad_in),
  .native_in      (native_in),
  .pad_oe         (pad_oe)
);

// File: tb/test_gpio_mux_bank.sv
`timescale 1ns/1ps
module test_gpio_mux_bank;

  localparam logic [11:0] IDLE = 12'hA5C;
  localparam logic [7:0]  A_MODE = 8'h40;
  localparam logic [7:0]  A_DIR  = 8'h44;

  logic        clk = 1'b0;
  logic        rst_resume_n;
  logic        rst_platform_n;
  logic        variant_mobile;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [11:0] native_out, native_oe, native_in, gpio_out, gpio_in, pad_in, pad_out, pad_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  gpio_mux_bank #(.NATIVE_IDLE(IDLE)) i_gpio_mux_bank (
    .clk(clk), .rst_resume_n(rst_resume_n), .rst_platform_n(rst_platform_n),
    .variant_mobile(variant_mobile), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .native_out(native_out), .native_oe(native_oe), .native_in(native_in),
    .gpio_out(gpio_out), .gpio_in(gpio_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic resume_reset(input logic mobile);
    @(negedge clk);
    rst_resume_n = 1'b0;
    #1 variant_mobile = mobile;
    repeat (2) @(negedge clk);
    rst_resume_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic platform_reset();
    @(negedge clk);
    rst_platform_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_platform_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_values();
    logic [31:0] d;
    resume_reset(1'b0);
    rd(A_MODE, d); check("R4", "desktop mode reset", d, 32'h130);
    rd(A_DIR, d);  check("R4", "desktop dir reset", d, 32'hD00);
    resume_reset(1'b1);
    rd(A_MODE, d); check("R4", "mobile mode reset", d, 32'h030);
    rd(A_DIR, d);  check("R4", "mobile dir reset", d, 32'hF00);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    resume_reset(1'b1);
    wr(A_MODE, 4'hF, 32'hFFFF_FFFF);
    rd(A_MODE, d); check("R1", "mode all ones", d, 32'hFFF);
    wr(A_DIR, 4'hF, 32'hFFFF_FFFF);
    rd(A_DIR, d);  check("R2", "dir all ones", d, 32'hF0F);
    wr(A_MODE, 4'hF, 32'h0);
    rd(A_MODE, d); check("R3", "mobile bit8 writable", d, 32'h000);
  endtask

  task automatic t_desktop_fixed();
    logic [31:0] d;
    resume_reset(1'b0);
    wr(A_MODE, 4'hF, 32'h0);
    rd(A_MODE, d); check("R3", "desktop bit8 stays one", d, 32'h100);
    wr(A_MODE, 4'hF, 32'hFFFF_FFFF);
    rd(A_MODE, d); check("R3", "desktop bit9 stays zero", d, 32'hDFF);
    wr(A_DIR, 4'hF, 32'hFFFF_FFFF);
    rd(A_DIR, d);  check("R3", "desktop dir bit9 zero", d, 32'hD0F);
    // pin 9 must stay native: native_out visible on pad_out
    @(negedge clk);
    native_out = 12'h200; gpio_out = 12'h000;
    #1 check("R3", "desktop pin9 native pad_out", {20'h0, pad_out & 12'h200}, 32'h200);
  endtask

  task automatic t_byte_enables();
    logic [31:0] d;
    resume_reset(1'b1);
    wr(A_MODE, 4'b0001, 32'hFFF);
    rd(A_MODE, d); check("R5", "low byte only", d, 32'h0FF);
    wr(A_MODE, 4'b0010, 32'h000);
    rd(A_MODE, d); check("R5", "upper byte cleared", d, 32'h0FF);
    wr(A_MODE, 4'b0010, 32'hA00);
    rd(A_MODE, d); check("R5", "upper byte written", d, 32'hAFF);
    wr(8'h48, 4'hF, 32'h0);
    rd(8'h48, d);  check("R5", "other address reads 0", d, 32'h0);
    rd(A_MODE, d); check("R5", "other address write ignored", d, 32'hAFF);
  endtask

  task automatic t_domains();
    logic [31:0] d;
    resume_reset(1'b1);
    wr(A_MODE, 4'hF, 32'hACE);
    wr(A_DIR, 4'hF, 32'h50A);
    platform_reset();
    rd(A_MODE, d); check("R6", "mode after platform reset", d, 32'hA30);
    rd(A_DIR, d);  check("R6", "dir after platform reset", d, 32'h500);
    resume_reset(1'b1);
    rd(A_MODE, d); check("R7", "mode after resume reset", d, 32'h030);
    rd(A_DIR, d);  check("R7", "dir after resume reset", d, 32'hF00);
  endtask

  task automatic t_write_during_reset();
    logic [31:0] d;
    resume_reset(1'b1);
    @(negedge clk);
    rst_platform_n = 1'b0;
    @(negedge clk);
    wr(A_MODE, 4'b0011, 32'hFFF);
    @(negedge clk);
    rst_platform_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_MODE, d); check("R6", "write during platform reset", d, 32'hF30);
  endtask

  task automatic t_mux_case(input logic [11:0] mode, input logic [11:0] dir_w,
                            input logic [11:0] no, input logic [11:0] noe,
                            input logic [11:0] go, input logic [11:0] pin);
    logic [11:0] dir;
    dir = dir_w & 12'hF0F;
    wr(A_MODE, 4'hF, {20'h0, mode});
    wr(A_DIR, 4'hF, {20'h0, dir_w});
    @(negedge clk);
    native_out = no; native_oe = noe; gpio_out = go; pad_in = pin;
    #1;
    check("R8", "pad_out", {20'h0, pad_out}, {20'h0, (mode & go) | (~mode & no)});
    check("R8", "pad_oe", {20'h0, pad_oe}, {20'h0, (mode & ~dir) | (~mode & noe)});
    check("R9", "native_in", {20'h0, native_in}, {20'h0, (mode & IDLE) | (~mode & pin)});
    check("R10", "gpio_in", {20'h0, gpio_in}, {20'h0, pin});
  endtask

  task automatic t_mux();
    resume_reset(1'b1);
    t_mux_case(12'h000, 12'hF0F, 12'h5A3, 12'h3C6, 12'hFFF, 12'h9B1);
    t_mux_case(12'hFFF, 12'h50A, 12'h5A3, 12'h3C6, 12'h6E5, 12'h9B1);
    t_mux_case(12'h0F0, 12'hA05, 12'hC3C, 12'hFFF, 12'h0F0, 12'h36C);
    t_mux_case(12'hA53, 12'h30C, 12'h000, 12'h000, 12'hFFF, 12'hFFF);
  endtask

  initial begin
    rst_resume_n = 1'b0; rst_platform_n = 1'b1; variant_mobile = 1'b0;
    reg_wr = 1'b0; reg_addr = 8'h40; reg_be = 4'h0; reg_wdata = '0;
    native_out = '0; native_oe = '0; gpio_out = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_resume_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_values();
    t_masks();
    t_desktop_fixed();
    t_byte_enables();
    t_domains();
    t_write_during_reset();
    t_mux();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule